// File: doc/BRIEF.md
# Firmware Overlay Bank Controller

This block decides what answers a memory access in the upper part of a 1 MiB address map. It keeps a small set of selection flags, which three byte-wide I/O ports update. For every memory address it reports which kind of target answers the access: system RAM, display memory, the extended RAM page, a firmware ROM, a writable shadow RAM, or nothing. It also reports which firmware bank is meant, whether the access may write, and whether a read sees an open bus. The storage behind each target lives elsewhere.

The top firmware region has a fixed order of precedence. The small interface ROM comes first, then the writable BIOS shadow RAM, then the BIOS ROM. Four expansion firmware windows sit in the 0xC0000–0xDFFFF area, and each one can be switched on or off. Two of them can also be turned into writable RAM. The address decode is purely combinational. Flag changes take effect at the clock edge that samples the I/O write strobe.

Top module: `fw_overlay_ctrl`

## Requirements
- R1: Addresses 0x00000–0x9FFFF decode as system RAM (kind 1, bank 0) and are writable.
- R2: Display memory (kind 2, bank 0, writable) answers 0xA0000–0xA4FFF, 0xA8000–0xAFFFF and 0xE0000–0xE7FFF. Addresses 0xA5000–0xA7FFF are unmapped.
- R3: A write of 0x00, 0x10 or 0x18 to I/O port 0x43D selects the interface ROM. A write of 0x02 or 0x12 to that port deselects it. Every other byte written to that port leaves the selection unchanged.
- R4: On port 0x43F, the byte 0x22 turns the extended RAM page on and 0x20 turns it off. While it is on, 0xB0000–0xBFFFF decodes as extended RAM (kind 3, writable). While it is off, that range decodes as display memory.
- R5: On port 0x43F, 0xC2 sets the RAM select of the window at 0xD7000 and 0xC4 sets the RAM select of the window at 0xDC000. 0xC0 clears both selects.
- R6: A write to port 0x53D loads all five flags from that byte. Bit 7 enables the window at 0xCC000, bit 6 the window at 0xD7000, bit 5 the window at 0xDC000 and bit 4 the window at 0xD8000. Bit 1 selects the BIOS shadow RAM.
- R7: In the top region 0xE8000–0xFFFFF, precedence runs as follows. If the interface ROM is selected, 0xF8000–0xFFFFF is ROM in bank 2, read-only, and 0xE8000–0xF7FFF is unmapped. Otherwise, if the BIOS shadow RAM is selected, the whole region is shadow RAM (kind 5, bank 1, writable). Otherwise the whole region is ROM (kind 4, bank 1, read-only).
- R8: The expansion windows are 0xCC000–0xCFFFF (bank 3), 0xD7000–0xD7FFF (bank 4), 0xD8000–0xDBFFF (bank 5) and 0xDC000–0xDCFFF (bank 6). A window that is disabled is unmapped. All other addresses in 0xC0000–0xDFFFF are unmapped.
- R9: An enabled window at bank 4 or bank 6 is shadow RAM (kind 5, writable) only while its RAM select is set, and ROM (kind 4, read-only) otherwise. Banks 3 and 5 are always ROM.
- R10: Kind codes are 0 for unmapped, 1 for system RAM, 2 for display, 3 for extended RAM, 4 for ROM and 5 for shadow RAM. The output wr_en is high only for a write (mem_wr=1) to a writable target. The output open_bus is high only for a read (mem_wr=0) of an unmapped address, which then returns 0xFF.
- R11: After reset, the interface ROM is selected, the BIOS shadow RAM is deselected, the extended RAM page is off, all four windows are disabled and both RAM selects are clear.
- R12: A flag changes only at the clock edge that samples io_wr high with a matching port address. During the cycle of the write itself, the decode still reflects the old flags. Writes to any other port address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per byte |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data byte |
| mem_addr | input | 20 | Memory access address |
| mem_wr | input | 1 | 1 = write access, 0 = read access |
| tgt_kind | output | 3 | Target kind code (R10) |
| tgt_bank | output | 3 | Firmware bank code, 0 when not firmware |
| wr_en | output | 1 | Write permitted for this access |
| open_bus | output | 1 | Read of an unmapped address, data reads 0xFF |

## Verification
The bench probes the first and last byte of every window and of every display range, together with the gaps between them. A decoder with an off-by-one bound therefore shows up as a mapped gap or a lost edge byte. It sends every command byte of the interface port, including values that should be ignored, so a decoder that keys on a single bit would wrongly toggle the selection. It sets each bit of the enable port on its own to catch swapped window enables. It selects the shadow RAM while the interface ROM is selected, so a wrong precedence would expose writable RAM in place of the read-only ROM. It also samples the decode during the cycle of a port write, to catch flags that update one cycle early.

// File: rtl/fwo_pkg.sv
package fwo_pkg;

  localparam int ADDR_W  = 20;
  localparam int NUM_WIN = 4;   // 0 sound, 1 sasi-like, 2 ide-like, 3 scsi-like
  localparam int DATA_W  = 8;

  typedef enum logic [2:0] {
    TK_NONE    = 3'd0,
    TK_SYSRAM  = 3'd1,
    TK_DISPLAY = 3'd2,
    TK_EMS     = 3'd3,
    TK_ROM     = 3'd4,
    TK_SHADOW  = 3'd5
  } tgt_kind_e;

  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_BIOS  = 3'd1,
    BK_IFACE = 3'd2,
    BK_SOUND = 3'd3,
    BK_SASI  = 3'd4,
    BK_IDE   = 3'd5,
    BK_SCSI  = 3'd6
  } bank_e;

  typedef struct packed {
    logic               iface_sel;
    logic               bios_ram;
    logic               ems_on;
    logic [NUM_WIN-1:0] fw_en;
    logic [NUM_WIN-1:0] fw_ram;
  } ovl_flags_t;

  // address map of the fixed zones
  localparam logic [ADDR_W-1:0] RAM_HI    = 20'h9FFFF;
  localparam logic [ADDR_W-1:0] DISP0_LO  = 20'hA0000;
  localparam logic [ADDR_W-1:0] DISP0_HI  = 20'hA4FFF;
  localparam logic [ADDR_W-1:0] DISP1_LO  = 20'hA8000;
  localparam logic [ADDR_W-1:0] DISP1_HI  = 20'hAFFFF;
  localparam logic [ADDR_W-1:0] EMS_LO    = 20'hB0000;
  localparam logic [ADDR_W-1:0] EMS_HI    = 20'hBFFFF;
  localparam logic [ADDR_W-1:0] EXT_LO    = 20'hC0000;
  localparam logic [ADDR_W-1:0] EXT_HI    = 20'hDFFFF;
  localparam logic [ADDR_W-1:0] DISP2_LO  = 20'hE0000;
  localparam logic [ADDR_W-1:0] DISP2_HI  = 20'hE7FFF;
  localparam logic [ADDR_W-1:0] BIOS_LO   = 20'hE8000;
  localparam logic [ADDR_W-1:0] IFACE_LO  = 20'hF8000;

  // bit of the enable port byte that loads the BIOS shadow select
  localparam int BRAM_BIT = 1;

  function automatic logic in_span(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] lo,
                                   input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [ADDR_W-1:0] win_lo(input int i);
    case (i)
      0:       return 20'hCC000;
      1:       return 20'hD7000;
      2:       return 20'hD8000;
      default: return 20'hDC000;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] win_hi(input int i);
    case (i)
      0:       return 20'hCFFFF;
      1:       return 20'hD7FFF;
      2:       return 20'hDBFFF;
      default: return 20'hDCFFF;
    endcase
  endfunction

  function automatic bank_e win_bank(input int i);
    case (i)
      0:       return BK_SOUND;
      1:       return BK_SASI;
      2:       return BK_IDE;
      default: return BK_SCSI;
    endcase
  endfunction

  function automatic logic win_has_ram(input int i);
    return (i == 1) || (i == 3);
  endfunction

  // position of each window's enable in the enable port byte
  function automatic logic [2:0] en_bit(input int i);
    case (i)
      0:       return 3'd7;
      1:       return 3'd6;
      2:       return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/fwo_flag_regs.sv
module fwo_flag_regs
  import fwo_pkg::*;
#(
  parameter int              IO_W       = 16,
  parameter logic [IO_W-1:0] IFACE_PORT = 16'h043D,
  parameter logic [IO_W-1:0] OPT_PORT   = 16'h043F,
  parameter logic [IO_W-1:0] EN_PORT    = 16'h053D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [IO_W-1:0]   io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output ovl_flags_t        flags
);

  localparam ovl_flags_t RESET_FLAGS = '{iface_sel: 1'b1, bios_ram: 1'b0,
                                         ems_on: 1'b0, fw_en: '0, fw_ram: '0};

  // named port hits for the assertions
  logic hit_iface, hit_opt, hit_en;
  assign hit_iface = io_wr && (io_addr == IFACE_PORT);
  assign hit_opt   = io_wr && (io_addr == OPT_PORT);
  assign hit_en    = io_wr && (io_addr == EN_PORT);

  ovl_flags_t nxt;

  always_comb begin
    nxt = flags;
    if (hit_iface) begin
      case (io_wdata)
        8'h00, 8'h10, 8'h18: nxt.iface_sel = 1'b1;
        8'h02, 8'h12:        nxt.iface_sel = 1'b0;
        default:             nxt.iface_sel = flags.iface_sel;
      endcase
    end
    if (hit_opt) begin
      case (io_wdata)
        8'h20: nxt.ems_on = 1'b0;
        8'h22: nxt.ems_on = 1'b1;
        8'hC0: begin
          nxt.fw_ram[1] = 1'b0;
          nxt.fw_ram[3] = 1'b0;
        end
        8'hC2: nxt.fw_ram[1] = 1'b1;
        8'hC4: nxt.fw_ram[3] = 1'b1;
        default: nxt.ems_on = flags.ems_on;
      endcase
    end
    if (hit_en) begin
      for (int i = 0; i < NUM_WIN; i++) nxt.fw_en[i] = io_wdata[en_bit(i)];
      nxt.bios_ram = io_wdata[BRAM_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= RESET_FLAGS;
    else        flags <= nxt;
  end

  assert_reset_state_R11: assert property (@(posedge clk)
    $rose(rst_n) |-> (flags.iface_sel && !flags.bios_ram && !flags.ems_on
                      && flags.fw_en == '0 && flags.fw_ram == '0));

  assert_iface_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_iface && (io_wdata inside {8'h00, 8'h10, 8'h18})) |=> flags.iface_sel);

  assert_iface_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_iface && (io_wdata inside {8'h02, 8'h12})) |=> !flags.iface_sel);

  assert_ems_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_opt && io_wdata == 8'h22) |=> flags.ems_on);

  assert_ram_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_opt && io_wdata == 8'hC0) |=> (flags.fw_ram == '0));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(flags));

endmodule

// File: rtl/fwo_map_decode.sv
module fwo_map_decode
  import fwo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ovl_flags_t        flags,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wr,
  output tgt_kind_e         kind,
  output bank_e             bank,
  output logic              wr_en,
  output logic              open_bus
);

  // zone hits, brought out for the assertions
  logic z_sys, z_disp, z_ems, z_ext, z_top;
  assign z_sys  = (mem_addr <= RAM_HI);
  assign z_disp = in_span(mem_addr, DISP0_LO, DISP0_HI)
               || in_span(mem_addr, DISP1_LO, DISP1_HI)
               || in_span(mem_addr, DISP2_LO, DISP2_HI);
  assign z_ems  = in_span(mem_addr, EMS_LO, EMS_HI);
  assign z_ext  = in_span(mem_addr, EXT_LO, EXT_HI);
  assign z_top  = (mem_addr >= BIOS_LO);

  logic [NUM_WIN-1:0] win_in, win_on, win_ram;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    assign win_in[gi]  = in_span(mem_addr, win_lo(gi), win_hi(gi));
    assign win_on[gi]  = win_in[gi] && flags.fw_en[gi];
    assign win_ram[gi] = flags.fw_ram[gi] && win_has_ram(gi);

    assert_window_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_in[gi] && !flags.fw_en[gi]) |-> (kind == TK_NONE));
  end

  logic can_wr;

  always_comb begin
    kind   = TK_NONE;
    bank   = BK_NONE;
    can_wr = 1'b0;
    if (z_sys) begin
      kind   = TK_SYSRAM;
      can_wr = 1'b1;
    end else if (z_disp) begin
      kind   = TK_DISPLAY;
      can_wr = 1'b1;
    end else if (z_ems) begin
      kind   = flags.ems_on ? TK_EMS : TK_DISPLAY;
      can_wr = 1'b1;
    end else if (z_ext) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (win_on[i]) begin
          kind   = win_ram[i] ? TK_SHADOW : TK_ROM;
          bank   = win_bank(i);
          can_wr = win_ram[i];
        end
      end
    end else if (z_top) begin
      if (flags.iface_sel) begin
        if (mem_addr >= IFACE_LO) begin
          kind = TK_ROM;
          bank = BK_IFACE;
        end
      end else if (flags.bios_ram) begin
        kind   = TK_SHADOW;
        bank   = BK_BIOS;
        can_wr = 1'b1;
      end else begin
        kind = TK_ROM;
        bank = BK_BIOS;
      end
    end
  end

  assign wr_en    = mem_wr && can_wr;
  assign open_bus = !mem_wr && (kind == TK_NONE);

  assert_rom_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TK_ROM) |-> !wr_en);

  assert_open_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    open_bus |-> (kind == TK_NONE && !mem_wr && !wr_en));

  assert_iface_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (z_top && flags.iface_sel) |-> (kind != TK_SHADOW && !wr_en));

  assert_sysram_R1: assert property (@(posedge clk) disable iff (!rst_n)
    z_sys |-> (kind == TK_SYSRAM && wr_en == mem_wr));

endmodule

// File: rtl/fw_overlay_ctrl.sv
module fw_overlay_ctrl
  import fwo_pkg::*;
#(
  parameter int              IO_W       = 16,
  parameter logic [IO_W-1:0] IFACE_PORT = 16'h043D,
  parameter logic [IO_W-1:0] OPT_PORT   = 16'h043F,
  parameter logic [IO_W-1:0] EN_PORT    = 16'h053D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [IO_W-1:0]   io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wr,
  output logic [2:0]        tgt_kind,
  output logic [2:0]        tgt_bank,
  output logic              wr_en,
  output logic              open_bus
);

  ovl_flags_t flags;
  tgt_kind_e  kind;
  bank_e      bank;

  fwo_flag_regs #(
    .IO_W       (IO_W),
    .IFACE_PORT (IFACE_PORT),
    .OPT_PORT   (OPT_PORT),
    .EN_PORT    (EN_PORT)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .flags    (flags)
  );

  fwo_map_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags    (flags),
    .mem_addr (mem_addr),
    .mem_wr   (mem_wr),
    .kind     (kind),
    .bank     (bank),
    .wr_en    (wr_en),
    .open_bus (open_bus)
  );

  assign tgt_kind = kind;
  assign tgt_bank = bank;

endmodule

// File: tb/fw_overlay_ctrl_tb.sv
module fw_overlay_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [19:0] mem_addr = '0;
  logic        mem_wr = 1'b0;
  logic [2:0]  tgt_kind, tgt_bank;
  logic        wr_en, open_bus;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_overlay_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .tgt_kind(tgt_kind), .tgt_bank(tgt_bank), .wr_en(wr_en), .open_bus(open_bus)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench-side model of the selection flags
  bit m_iface = 1, m_bram = 0, m_ems = 0;
  bit m_snd = 0, m_sasi = 0, m_ide = 0, m_scsi = 0;
  bit m_sasi_ram = 0, m_scsi_ram = 0;

  typedef struct {
    logic [19:0] a;
    logic [7:0]  exp;
    string       req;
  } item_t;
  item_t sbq[$];

  // expected {kind, bank, wr_en, open_bus}
  function automatic logic [7:0] predict(input logic [19:0] a, input bit w);
    int k = 0, b = 0;
    bit can = 0;
    if (a >= 20'hE8000) begin
      if (m_iface) begin
        if (a >= 20'hF8000) begin k = 4; b = 2; end
      end else if (m_bram) begin k = 5; b = 1; can = 1; end
      else begin k = 4; b = 1; end
    end else if (a >= 20'hE0000) begin k = 2; can = 1; end
    else if (a >= 20'hC0000) begin
      if (a >= 20'hCC000 && a <= 20'hCFFFF && m_snd) begin k = 4; b = 3; end
      else if (a >= 20'hD7000 && a <= 20'hD7FFF && m_sasi) begin
        b = 4; k = m_sasi_ram ? 5 : 4; can = m_sasi_ram;
      end else if (a >= 20'hD8000 && a <= 20'hDBFFF && m_ide) begin k = 4; b = 5; end
      else if (a >= 20'hDC000 && a <= 20'hDCFFF && m_scsi) begin
        b = 6; k = m_scsi_ram ? 5 : 4; can = m_scsi_ram;
      end
    end else if (a >= 20'hB0000) begin k = m_ems ? 3 : 2; can = 1; end
    else if (a >= 20'hA8000) begin k = 2; can = 1; end
    else if (a >= 20'hA5000) begin k = 0; end
    else if (a >= 20'hA0000) begin k = 2; can = 1; end
    else begin k = 1; can = 1; end
    return {k[2:0], b[2:0], w & can, ~w & (k == 0)};
  endfunction

  task automatic compare(input string req, input logic [19:0] a, input logic [7:0] exp);
    logic [7:0] got;
    got = {tgt_kind, tgt_bank, wr_en, open_bus};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%05h got kind=%0d bank=%0d we=%0b ob=%0b exp kind=%0d bank=%0d we=%0b ob=%0b",
               req, a, got[7:5], got[4:2], got[1], got[0], exp[7:5], exp[4:2], exp[1], exp[0]);
    end
  endtask

  // driver: apply an access and push its expectation
  task automatic probe(input logic [19:0] a, input bit w, input string req);
    item_t it;
    @(negedge clk);
    mem_addr = a;
    mem_wr   = w;
    it.a = a; it.exp = predict(a, w); it.req = req;
    sbq.push_back(it);
  endtask

  // monitor: compare once per cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      compare(it.req, it.a, it.exp);
    end
  end

  task automatic model_io(input logic [15:0] p, input logic [7:0] d);
    case (p)
      16'h043D: begin
        if (d == 8'h00 || d == 8'h10 || d == 8'h18) m_iface = 1;
        else if (d == 8'h02 || d == 8'h12) m_iface = 0;
      end
      16'h043F: begin
        if (d == 8'h20) m_ems = 0;
        if (d == 8'h22) m_ems = 1;
        if (d == 8'hC0) begin m_sasi_ram = 0; m_scsi_ram = 0; end
        if (d == 8'hC2) m_sasi_ram = 1;
        if (d == 8'hC4) m_scsi_ram = 1;
      end
      16'h053D: begin
        m_snd = d[7]; m_sasi = d[6]; m_scsi = d[5]; m_ide = d[4]; m_bram = d[1];
      end
      default: ;
    endcase
  endtask

  task automatic io_write(input logic [15:0] p, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1; io_addr = p; io_wdata = d;
    @(negedge clk);
    io_wr = 0;
    model_io(p, d);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R11 reset state
    probe(20'hF8000, 0, "R11 iface rom after reset");
    probe(20'hE8000, 0, "R11 lower top unmapped after reset");
    probe(20'hB0000, 1, "R11 ems off after reset");
    probe(20'hCC000, 0, "R11 windows off after reset");
    probe(20'hD7000, 0, "R11 windows off after reset");

    // R1 system RAM
    probe(20'h00000, 1, "R1 ram write");
    probe(20'h9FFFF, 0, "R1 ram read top");

    // R2 display ranges and gap
    probe(20'hA0000, 1, "R2 display low");
    probe(20'hA4FFF, 0, "R2 display end");
    probe(20'hA5000, 0, "R2 gap start");
    probe(20'hA7FFF, 1, "R2 gap end write");
    probe(20'hA8000, 1, "R2 display mid");
    probe(20'hE0000, 1, "R2 display high");
    probe(20'hE7FFF, 0, "R2 display high end");

    // R3 interface port commands
    io_write(16'h043D, 8'h02);
    probe(20'hF8000, 1, "R3 deselect 02");
    io_write(16'h043D, 8'h55);
    probe(20'hE8000, 0, "R3 other byte ignored");
    io_write(16'h043D, 8'h10);
    probe(20'hE8000, 0, "R3 select 10");
    io_write(16'h043D, 8'h01);
    probe(20'hFFFFF, 0, "R3 other byte ignored while selected");
    io_write(16'h043D, 8'h12);
    probe(20'hFFFFF, 1, "R3 deselect 12");
    io_write(16'h043D, 8'h18);
    probe(20'hF8000, 0, "R3 select 18");
    io_write(16'h043D, 8'h02);
    io_write(16'h043D, 8'h00);
    probe(20'hF7FFF, 0, "R3 select 00");

    // R6/R7 BIOS shadow with precedence
    io_write(16'h053D, 8'h02);
    probe(20'hE8000, 1, "R7 iface over shadow");
    probe(20'hF8000, 1, "R7 iface rom not writable");
    io_write(16'h043D, 8'h02);
    probe(20'hE8000, 1, "R7 shadow writable");
    probe(20'hFFFFF, 0, "R7 shadow read");
    io_write(16'h053D, 8'h00);
    probe(20'hE8000, 1, "R7 bios rom read-only");

    // R6 single enable bits
    io_write(16'h053D, 8'h80);
    probe(20'hCC000, 0, "R6 bit7 window");
    probe(20'hD7000, 0, "R6 bit7 only");
    io_write(16'h053D, 8'h40);
    probe(20'hD7000, 0, "R6 bit6 window");
    probe(20'hCC000, 0, "R6 bit6 only");
    io_write(16'h053D, 8'h20);
    probe(20'hDC000, 0, "R6 bit5 window");
    probe(20'hD8000, 0, "R6 bit5 only");
    io_write(16'h053D, 8'h10);
    probe(20'hD8000, 0, "R6 bit4 window");
    probe(20'hDC000, 0, "R6 bit4 only");

    // R8 window bounds and gaps
    io_write(16'h053D, 8'hF0);
    probe(20'hCBFFF, 0, "R8 below sound");
    probe(20'hCFFFF, 0, "R8 sound end");
    probe(20'hD0000, 0, "R8 gap");
    probe(20'hD6FFF, 0, "R8 below sasi");
    probe(20'hD7FFF, 0, "R8 sasi end");
    probe(20'hDBFFF, 0, "R8 ide end");
    probe(20'hDCFFF, 0, "R8 scsi end");
    probe(20'hDD000, 0, "R8 above scsi");
    probe(20'hC0000, 1, "R8 ext start unmapped write");

    // R5/R9 RAM selects
    probe(20'hCC000, 1, "R9 sound rom write blocked");
    probe(20'hD7000, 1, "R9 sasi rom write blocked");
    io_write(16'h043F, 8'hC2);
    probe(20'hD7000, 1, "R5 sasi ram writable");
    probe(20'hDC000, 1, "R5 scsi still rom");
    io_write(16'h043F, 8'hC4);
    probe(20'hDC000, 1, "R5 scsi ram writable");
    probe(20'hD8000, 1, "R9 ide never writable");
    io_write(16'h043F, 8'hC0);
    probe(20'hD7000, 1, "R5 clear sasi");
    probe(20'hDC000, 1, "R5 clear scsi");
    io_write(16'h043F, 8'hC2);
    io_write(16'h053D, 8'h00);
    probe(20'hD7000, 1, "R9 disabled window with ram select");

    // R4 extended RAM page
    io_write(16'h043F, 8'h22);
    probe(20'hB0000, 1, "R4 ems on");
    probe(20'hBFFFF, 0, "R4 ems end");
    probe(20'hAFFFF, 1, "R4 below ems stays display");
    io_write(16'h043F, 8'h20);
    probe(20'hB0000, 1, "R4 ems off");

    // R12 other ports ignored
    io_write(16'h043E, 8'h22);
    probe(20'hB0000, 0, "R12 wrong port ignored");
    io_write(16'h053C, 8'hFF);
    probe(20'hCC000, 0, "R12 wrong port ignored");

    // R12 decode holds old flags during the write cycle
    @(negedge clk);
    mem_addr = 20'hE8000; mem_wr = 0;
    io_wr = 1; io_addr = 16'h043D; io_wdata = 8'h00;
    #1;
    compare("R12 before edge", mem_addr, predict(mem_addr, 0));
    model_io(16'h043D, 8'h00);
    @(posedge clk);
    #1;
    compare("R12 after edge", mem_addr, predict(mem_addr, 0));
    @(negedge clk);
    io_wr = 0;

    // R10 open bus only on reads
    probe(20'hA6000, 0, "R10 open bus read");
    probe(20'hA6000, 1, "R10 no open bus on write");

    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule